// File: doc/BRIEF.md
# Entropy Accumulator with Read Interlock

This block turns three raw one-bit noise inputs into 64-bit random words. Each input has its own enable. On every clock the enabled bits are combined by XOR into one feed bit, and that bit is shifted into a 64-bit CRC register with a fixed generator polynomial. The register keeps running at all times, and its contents are the random word that a reader sees.

A control register sets the source enables, an interlock mode bit, a two-bit output select, a VCO select value and a wait count. Each oscillator's VCO setting is loaded by a control write that turns on that source's enable bit alone. Firmware therefore programs the three sources one at a time and then writes a final value with all enables set. In interlock mode a reader uses a valid/ready handshake. After each accepted read, ready stays low for the programmed number of cycles, so that enough fresh entropy has entered the register before the next word is returned. One output-select code blanks the data during diagnostics.

Top module: `rng_crc_interlock`

## Requirements
- R1: After reset the CRC state, the control register and all VCO selects are zero and `rd_ready_o` is high. With no enable set, `rd_data_o` stays zero while the raw inputs toggle.
- R2: The feed bit is the XOR of `src_i[k] & en[k]` over all sources, where enable k is control bit k. A disabled source has no effect on the CRC.
- R3: On each clock, state' = (state << 1) XOR (P if (state[63] XOR feed) else 0), with P = 64'h231DCEE91262B8A3. P holds the low 64 terms of a polynomial with x^64, 61, 57, 56, 52, 51, 50, 48, 47, 46, 43, 42, 41, 39, 38, 37, 35, 32, 28, 25, 22, 21, 17, 15, 13, 12, 11, 7, 5, 1 and 1.
- R4: When the output select (control bits [5:4]) is not 2, `rd_data_o` equals the current CRC state.
- R5: When the mode bit (control bit 3) is set, an accepted read (valid and ready at a clock edge) loads the wait field (control bits [23:8]) into a counter. `rd_ready_o` is then low for exactly that many cycles.
- R6: With the mode bit set and a wait of zero, `rd_ready_o` stays high across back-to-back reads.
- R7: With the mode bit clear, `rd_ready_o` is always high.
- R8: A read held with `rd_valid_i` high while ready is low is accepted in the first cycle that ready rises, and returns the CRC state of that cycle.
- R9: A control write whose enable field has exactly one bit k set copies the VCO field (control bits [7:6]) into `vco_sel_o[2k+1:2k]`. Any other write leaves every VCO select unchanged.
- R10: When the output select is 2, `rd_data_o` is zero while the CRC state keeps advancing. After the select returns to 0, the data again matches the running state.
- R11: The CRC state advances on every clock whether or not a read is pending or accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| src_i | input | 3 | Raw entropy bits, already synchronized |
| ctl_we_i | input | 1 | Control register write strobe |
| ctl_wdata_i | input | 24 | Control write value: [2:0] enables, [3] mode, [5:4] output select, [7:6] VCO, [23:8] wait |
| rd_valid_i | input | 1 | Read request |
| rd_ready_o | output | 1 | Read may be accepted this cycle |
| rd_data_o | output | 64 | Random word |
| vco_sel_o | output | 6 | Per-source VCO selects, 2 bits per source |

## Verification
The assertions take the raw bits as clean, synchronized levels that change only between clock edges. They assume that a control write does not land in the same cycle as an accepted read whose stall they check, so the interlock properties carry that condition. The stimulus changes the sources, the handshake and the writes one time unit after each rising edge. It always finishes a write before it issues the next read. A reference model in the bench tracks the CRC state, the wait counter and the VCO selects from the same stimulus.

// File: rtl/rci_pkg.sv
`timescale 1ns/1ps
package rci_pkg;
  localparam int CRC_W = 64;
  localparam logic [CRC_W-1:0] CRC_POLY = 64'h231D_CEE9_1262_B8A3;

  typedef enum logic [1:0] {
    OSEL_NORM  = 2'd0,
    OSEL_ALT   = 2'd1,
    OSEL_QUIET = 2'd2,
    OSEL_RSVD  = 2'd3
  } osel_e;
endpackage

// File: rtl/rci_ctl_regs.sv
`timescale 1ns/1ps
module rci_ctl_regs
  import rci_pkg::*;
#(
  parameter int NSRC   = 3,
  parameter int VCO_W  = 2,
  parameter int WAIT_W = 16,
  localparam int MODE_BIT = NSRC,
  localparam int OSEL_LSB = NSRC + 1,
  localparam int VCO_LSB  = NSRC + 3,
  localparam int WAIT_LSB = NSRC + 3 + VCO_W,
  localparam int CTL_W    = WAIT_LSB + WAIT_W
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    we_i,
  input  logic [CTL_W-1:0]        wdata_i,
  output logic [NSRC-1:0]         en_o,
  output logic                    mode_o,
  output osel_e                   osel_o,
  output logic [WAIT_W-1:0]       wait_o,
  output logic [NSRC*VCO_W-1:0]   vco_o
);
  logic [CTL_W-1:0] ctl_q;
  logic [NSRC-1:0]  wr_en;
  logic             single_src;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   ctl_q <= '0;
    else if (we_i) ctl_q <= wdata_i;
  end

  assign wr_en      = wdata_i[NSRC-1:0];
  // exactly one enable set selects the source whose VCO is programmed
  assign single_src = (wr_en != '0) && ((wr_en & (wr_en - 1'b1)) == '0);

  for (genvar k = 0; k < NSRC; k++) begin : g_vco
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)
        vco_o[k*VCO_W +: VCO_W] <= '0;
      else if (we_i && single_src && wr_en[k])
        vco_o[k*VCO_W +: VCO_W] <= wdata_i[VCO_LSB +: VCO_W];
    end
  end

  assign en_o   = ctl_q[NSRC-1:0];
  assign mode_o = ctl_q[MODE_BIT];
  assign osel_o = osel_e'(ctl_q[OSEL_LSB +: 2]);
  assign wait_o = ctl_q[WAIT_LSB +: WAIT_W];
endmodule

// File: rtl/rci_crc_accum.sv
`timescale 1ns/1ps
module rci_crc_accum
  import rci_pkg::*;
#(
  parameter int NSRC = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NSRC-1:0]   src_i,
  input  logic [NSRC-1:0]   en_i,
  output logic [CRC_W-1:0]  crc_o
);
  logic [NSRC-1:0]  gated;
  logic             feed;
  logic             fb;
  logic [CRC_W-1:0] crc_d;

  for (genvar k = 0; k < NSRC; k++) begin : g_gate
    assign gated[k] = src_i[k] & en_i[k];
  end

  assign feed  = ^gated;
  assign fb    = crc_o[CRC_W-1] ^ feed;
  assign crc_d = {crc_o[CRC_W-2:0], 1'b0} ^ (fb ? CRC_POLY : '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) crc_o <= '0;
    else         crc_o <= crc_d;
  end
endmodule

// File: rtl/rci_interlock.sv
`timescale 1ns/1ps
module rci_interlock #(
  parameter int WAIT_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              accept_i,
  input  logic              mode_i,
  input  logic [WAIT_W-1:0] wait_i,
  output logic              ready_o
);
  logic [WAIT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (accept_i)      cnt_q <= wait_i;
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign ready_o = !mode_i || (cnt_q == '0);
endmodule

// File: rtl/rng_crc_interlock.sv
`timescale 1ns/1ps
module rng_crc_interlock
  import rci_pkg::*;
#(
  parameter int NSRC   = 3,
  parameter int VCO_W  = 2,
  parameter int WAIT_W = 16,
  localparam int CTL_W = NSRC + 3 + VCO_W + WAIT_W
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic [NSRC-1:0]       src_i,
  input  logic                  ctl_we_i,
  input  logic [CTL_W-1:0]      ctl_wdata_i,
  input  logic                  rd_valid_i,
  output logic                  rd_ready_o,
  output logic [CRC_W-1:0]      rd_data_o,
  output logic [NSRC*VCO_W-1:0] vco_sel_o
);
  logic [NSRC-1:0]   src_en;
  logic              ilk_mode;
  osel_e             out_sel;
  logic [WAIT_W-1:0] wait_val;
  logic [CRC_W-1:0]  crc_q;
  logic              rd_accept;

  rci_ctl_regs #(.NSRC(NSRC), .VCO_W(VCO_W), .WAIT_W(WAIT_W)) u_ctl (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (ctl_we_i),
    .wdata_i(ctl_wdata_i),
    .en_o   (src_en),
    .mode_o (ilk_mode),
    .osel_o (out_sel),
    .wait_o (wait_val),
    .vco_o  (vco_sel_o)
  );

  rci_crc_accum #(.NSRC(NSRC)) u_crc (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .src_i (src_i),
    .en_i  (src_en),
    .crc_o (crc_q)
  );

  assign rd_accept = rd_valid_i && rd_ready_o;

  rci_interlock #(.WAIT_W(WAIT_W)) u_ilk (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .accept_i(rd_accept),
    .mode_i  (ilk_mode),
    .wait_i  (wait_val),
    .ready_o (rd_ready_o)
  );

  assign rd_data_o = (out_sel == OSEL_QUIET) ? '0 : crc_q;
endmodule

// File: rtl/rci_checker.sv
`timescale 1ns/1ps
module rci_checker
  import rci_pkg::*;
#(
  parameter int NSRC   = 3,
  parameter int VCO_W  = 2,
  parameter int WAIT_W = 16
) (
  input logic                  clk_i,
  input logic                  rst_ni,
  input logic [NSRC-1:0]       src_i,
  input logic [NSRC-1:0]       en_i,
  input logic                  mode_i,
  input logic [1:0]            osel_i,
  input logic [WAIT_W-1:0]     wait_i,
  input logic [CRC_W-1:0]      crc_i,
  input logic                  ctl_we_i,
  input logic                  rd_valid_i,
  input logic                  rd_ready_i,
  input logic [CRC_W-1:0]      rd_data_i,
  input logic [NSRC*VCO_W-1:0] vco_i
);
  p_feed_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> crc_i[0] == ($past(crc_i[CRC_W-1]) ^ (^($past(src_i & en_i)))));

  p_shift_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> crc_i[3] == $past(crc_i[2]));

  p_data_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (osel_i != 2'd2) |-> rd_data_i == crc_i);

  p_quiet_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (osel_i == 2'd2) |-> rd_data_i == '0);

  p_stall_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_valid_i && rd_ready_i && mode_i && wait_i != '0 && !ctl_we_i) |=> !rd_ready_i);

  p_zero_wait_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_valid_i && rd_ready_i && wait_i == '0 && !ctl_we_i) |=> rd_ready_i);

  p_free_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mode_i |-> rd_ready_i);

  p_vco_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ctl_we_i |=> $stable(vco_i));
endmodule

bind rng_crc_interlock rci_checker #(.NSRC(NSRC), .VCO_W(VCO_W), .WAIT_W(WAIT_W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .src_i     (src_i),
  .en_i      (src_en),
  .mode_i    (ilk_mode),
  .osel_i    (out_sel),
  .wait_i    (wait_val),
  .crc_i     (crc_q),
  .ctl_we_i  (ctl_we_i),
  .rd_valid_i(rd_valid_i),
  .rd_ready_i(rd_ready_o),
  .rd_data_i (rd_data_o),
  .vco_i     (vco_sel_o)
);

// File: tb/rng_crc_interlock_test.sv
`timescale 1ns/1ps
module rng_crc_interlock_test;
  localparam logic [63:0] P = 64'h231DCEE91262B8A3;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  src = '0;
  logic        we = 1'b0;
  logic [23:0] wdata = '0;
  logic        vld = 1'b0;
  logic        rdy;
  logic [63:0] data;
  logic [5:0]  vco;

  int total = 0;
  int bad = 0;
  bit done = 0;
  string cur_req = "R1";
  string exp_q[$];

  // reference model state
  logic [63:0] m_crc;
  logic [23:0] m_ctl;
  logic [15:0] m_cnt;
  logic [5:0]  m_vco;
  logic [15:0] rnd;

  always #4 clk = ~clk;

  rng_crc_interlock uut (
    .clk_i(clk), .rst_ni(rst_n), .src_i(src), .ctl_we_i(we), .ctl_wdata_i(wdata),
    .rd_valid_i(vld), .rd_ready_o(rdy), .rd_data_o(data), .vco_sel_o(vco)
  );

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  // raw entropy stimulus
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) rnd <= 16'hACE1;
    else begin
      rnd <= {rnd[14:0], rnd[15] ^ rnd[13] ^ rnd[12] ^ rnd[10]};
      src <= #1 {rnd[11], rnd[5], rnd[0]};
    end
  end

  function automatic bit m_ready();
    return !m_ctl[3] || (m_cnt == 16'd0);
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_crc <= '0; m_ctl <= '0; m_cnt <= '0; m_vco <= '0;
    end else begin
      logic fb;
      fb = m_crc[63] ^ (^(src & m_ctl[2:0]));
      m_crc <= {m_crc[62:0], 1'b0} ^ (fb ? P : 64'd0);
      if (vld && m_ready()) m_cnt <= m_ctl[23:8];
      else if (m_cnt != 0) m_cnt <= m_cnt - 1'b1;
      if (we) begin
        m_ctl <= wdata;
        case (wdata[2:0])
          3'b001: m_vco[1:0] <= wdata[7:6];
          3'b010: m_vco[3:2] <= wdata[7:6];
          3'b100: m_vco[5:4] <= wdata[7:6];
          default: ;
        endcase
      end
    end
  end

  // monitor / scoreboard
  always @(negedge clk) begin
    if (rst_n && !done) begin
      logic [63:0] exp_d;
      check(rdy == m_ready(), {cur_req, " ready"}, {63'd0, rdy}, {63'd0, m_ready()});
      check(vco == m_vco, "R9 vco", {58'd0, vco}, {58'd0, m_vco});
      if (vld && rdy) begin
        string tag;
        exp_d = (m_ctl[5:4] == 2'd2) ? 64'd0 : m_crc;
        if (exp_q.size() == 0) check(1'b0, "scoreboard empty", 64'd0, 64'd1);
        else begin
          tag = exp_q.pop_front();
          check(data == exp_d, tag, data, exp_d);
        end
      end
    end
  end

  task automatic wr_ctl(input logic [2:0] en, input bit mode, input logic [1:0] osel,
                        input logic [1:0] vs, input logic [15:0] w);
    @(posedge clk); #1;
    we = 1'b1; wdata = {w, vs, osel, mode, en};
    @(posedge clk); #1;
    we = 1'b0;
  endtask

  task automatic rd(input string req);
    exp_q.push_back(req);
    cur_req = req;
    @(posedge clk); #1 vld = 1'b1;
    @(negedge clk);
    while (!rdy) @(negedge clk);
    @(posedge clk); #1 vld = 1'b0;
  endtask

  task automatic stall(input logic [15:0] w, input string req);
    int n;
    rd(req);
    n = 0;
    @(negedge clk);
    while (!rdy && n < 70000) begin n++; @(negedge clk); end
    check(n == int'(w), {req, " stall length"}, 64'(n), 64'(w));
  endtask

  initial begin
    #(8 * 150000);
    bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    check(data == 64'd0, "R1 data", data, 64'd0);
    check(rdy == 1'b1, "R1 ready", {63'd0, rdy}, 64'd1);
    check(vco == 6'd0, "R1 vco", {58'd0, vco}, 64'd0);
    repeat (20) @(negedge clk);
    check(data == 64'd0, "R1 R2 disabled sources", data, 64'd0);

    // per-source VCO programming, then final configuration
    cur_req = "R9";
    wr_ctl(3'b001, 1'b0, 2'd0, 2'd1, 16'd0);
    wr_ctl(3'b010, 1'b0, 2'd0, 2'd2, 16'd0);
    wr_ctl(3'b100, 1'b0, 2'd0, 2'd3, 16'd0);
    wr_ctl(3'b111, 1'b0, 2'd0, 2'd0, 16'd4);
    @(negedge clk);
    check(vco == 6'b11_10_01, "R9 vco after multi-enable write", {58'd0, vco}, 64'b11_10_01);

    // no interlock: reads always accepted
    for (int i = 0; i < 4; i++) rd("R7");
    for (int i = 0; i < 3; i++) rd("R3");
    repeat (10) @(negedge clk);
    rd("R11");

    // single source feeds the CRC
    wr_ctl(3'b010, 1'b0, 2'd0, 2'd0, 16'd0);
    check(vco == 6'b11_00_01, "R9 vco single write", {58'd0, vco}, 64'b11_00_01);
    for (int i = 0; i < 3; i++) rd("R2");

    // interlock mode
    wr_ctl(3'b111, 1'b1, 2'd0, 2'd0, 16'd5);
    stall(16'd5, "R5");
    rd("R8");
    rd("R8");
    wr_ctl(3'b111, 1'b1, 2'd1, 2'd0, 16'd1);
    stall(16'd1, "R5");
    wr_ctl(3'b111, 1'b1, 2'd0, 2'd0, 16'd37);
    stall(16'd37, "R5");
    rd("R4");

    wr_ctl(3'b101, 1'b1, 2'd0, 2'd0, 16'd0);
    stall(16'd0, "R6");
    for (int i = 0; i < 4; i++) rd("R6");

    // quiet output
    wr_ctl(3'b111, 1'b0, 2'd2, 2'd0, 16'd0);
    for (int i = 0; i < 3; i++) rd("R10");
    @(negedge clk);
    check(data == 64'd0, "R10 quiet data", data, 64'd0);
    wr_ctl(3'b111, 1'b0, 2'd0, 2'd0, 16'd0);
    rd("R10");
    @(negedge clk);
    check(data == m_crc && data != 64'd0, "R10 R4 resumed data", data, m_crc);

    repeat (4) @(negedge clk);
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule